// File: doc/BRIEF.md
# Receive Ring Buffer Write Controller

This block takes a stream of received halfwords, framed by start and end strobes, and stores each frame into a circular region of a 16-bit packet memory. Every stored frame begins with a six-halfword (12-byte) header slot. The payload follows the header, and padding is added so that each frame occupies a whole number of 32-bit words. Once the payload is in memory, the block writes the payload byte count back into the header. Only then does it commit the frame by moving its hardware write cursor past the frame.

Software stages a ring start, a ring limit and a write-cursor preset. None of these takes effect until a control write with the latch flag set. Software also keeps a read cursor, and the block never overwrites the halfword at that cursor. A frame that would collide with the read cursor is abandoned, and a sticky overflow flag records the event.

All cursors are halfword indices into packet memory. The byte address of an index is twice the index plus the base of packet memory. The block emits one-cycle pulses when a frame begins, when a frame is committed, and for every frame seen whether or not it was stored.

Top module: `rxring_ctrl`

## Requirements
- R1: After reset, the write cursor, the units count and the overflow flag read zero. No memory write or pulse is output, and storing is disabled.
- R2: A control write with `ctl_latch` high copies `cfg_begin` and `cfg_end` into the active ring bounds, loads the write cursor from `cfg_wlatch`, and clears the overflow flag. Staged values changed without a latch have no effect.
- R3: When the store-enable flag is clear (it is taken from `ctl_store_en` on each control write), a frame causes no memory write and leaves the write cursor unchanged.
- R4: A stored frame writes six zero header halfwords starting at the write cursor, then the payload halfwords in arrival order. Finally, header halfword 4 (byte offset +8) receives the payload length in bytes, which is twice the payload halfword count.
- R5: When header plus payload is an odd number of halfwords, one zero pad halfword follows the payload. The committed cursor therefore always advances by an even number of halfwords.
- R6: A write position that steps onto the ring limit (`cfg_end`, the first index after the ring) continues at the ring start. Every write lands inside the active ring.
- R7: No write is made at a position whose successor is the read cursor. On such a collision the frame is dropped: the write cursor stays unchanged, the units count returns to zero, and the sticky overflow flag is set.
- R8: `rx_units` counts the halfwords written since the current frame began. It reads 6 once the header is written, and returns to 0 on commit.
- R9: `rx_start` pulses for one cycle after `in_start`. `rx_done` pulses once per committed frame. `rx_count` pulses once per frame, whether it was stored, dropped or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_store_en | input | 1 | Store-enable flag captured on a control write |
| ctl_latch | input | 1 | Latch flag: apply staged ring bounds and cursor preset |
| cfg_begin | input | AW | Staged ring start (halfword index) |
| cfg_end | input | AW | Staged ring limit, first index after the ring |
| cfg_wlatch | input | AW | Staged write-cursor preset |
| rd_csr | input | AW | Software read cursor |
| in_start | input | 1 | Frame start strobe |
| in_valid | input | 1 | Payload halfword valid |
| in_data | input | DW | Payload halfword |
| in_end | input | 1 | Frame end strobe |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | AW | Packet memory halfword index |
| mem_wdata | output | DW | Packet memory write data |
| rx_start | output | 1 | Frame-start pulse |
| rx_done | output | 1 | Frame-committed pulse |
| rx_count | output | 1 | Per-frame pulse |
| hw_wcsr | output | AW | Committed hardware write cursor |
| rx_units | output | AW | Halfwords written in the current frame |
| rx_ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions rely on several rules about the input stream:
- `in_start` comes only while the sequencer is idle.
- `in_valid` is held low during the six header cycles and never coincides with `in_end`.
- Latch writes happen only between frames.
- The ring start lies below the ring limit, and the read cursor lies inside the ring.

The stimulus keeps to these rules. After each start strobe it waits seven cycles before the first payload halfword, it raises the end strobe alone, and it leaves several idle cycles after every frame. Ring reconfiguration and read-cursor moves happen only during those idle gaps.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_LEN,
    ST_SKIP
  } rx_state_t;

  localparam int HDR_HALFWORDS = 6;
  localparam int LEN_SLOT      = 4;
endpackage

// File: rtl/rxring_wrap.sv
module rxring_wrap #(
  parameter int AW = 12
) (
  input  logic [AW-1:0] pos,
  input  logic [AW-1:0] ring_begin,
  input  logic [AW-1:0] ring_end,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] inc;

  always_comb begin
    inc = pos + 1'b1;
    nxt = (inc == ring_end) ? ring_begin : inc;
  end
endmodule

// File: rtl/rxring_cfg.sv
module rxring_cfg #(
  parameter int          AW        = 12,
  parameter logic [AW-1:0] RST_BEGIN = '0,
  parameter logic [AW-1:0] RST_END   = AW'(1024)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_store_en,
  input  logic          ctl_latch,
  input  logic [AW-1:0] cfg_begin,
  input  logic [AW-1:0] cfg_end,
  output logic [AW-1:0] act_begin,
  output logic [AW-1:0] act_end,
  output logic          store_en,
  output logic          latch_evt
);
  assign latch_evt = ctl_wr & ctl_latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_begin <= RST_BEGIN;
      act_end   <= RST_END;
      store_en  <= 1'b0;
    end else begin
      if (ctl_wr) store_en <= ctl_store_en;
      if (latch_evt) begin
        act_begin <= cfg_begin;
        act_end   <= cfg_end;
      end
    end
  end

  assert_latch_copies_R2: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> (act_begin == $past(cfg_begin)) && (act_end == $past(cfg_end)));

  assert_hold_without_latch_R2: assert property (@(posedge clk) disable iff (rst)
    !latch_evt |=> $stable(act_begin) && $stable(act_end));
endmodule

// File: rtl/rxring_seq.sv
module rxring_seq
  import rxring_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] act_begin,
  input  logic [AW-1:0] act_end,
  input  logic          store_en,
  input  logic          latch_evt,
  input  logic [AW-1:0] wlatch,
  input  logic [AW-1:0] rd_csr,
  input  logic          in_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_end,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          start_p,
  output logic          done_p,
  output logic          count_p,
  output logic [AW-1:0] wcsr,
  output logic [AW-1:0] units,
  output logic          ovf
);
  localparam logic [2:0] HDR_LAST = 3'(HDR_HALFWORDS - 1);
  localparam logic [2:0] LEN_IDX  = 3'(LEN_SLOT);

  rx_state_t     state;
  logic [AW-1:0] wr_pos;
  logic [AW-1:0] wr_nxt;
  logic [AW-1:0] len_pos;
  logic [AW-1:0] pay_cnt;
  logic [2:0]    hdr_idx;
  logic          space_ok;

  rxring_wrap #(.AW(AW)) u_step (
    .pos       (wr_pos),
    .ring_begin(act_begin),
    .ring_end  (act_end),
    .nxt       (wr_nxt)
  );

  assign space_ok = (wr_nxt != rd_csr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wr_pos    <= '0;
      len_pos   <= '0;
      pay_cnt   <= '0;
      hdr_idx   <= '0;
      wcsr      <= '0;
      units     <= '0;
      ovf       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      start_p   <= 1'b0;
      done_p    <= 1'b0;
      count_p   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      start_p <= 1'b0;
      done_p  <= 1'b0;
      count_p <= 1'b0;

      if (latch_evt) begin
        wcsr <= wlatch;
        ovf  <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (in_start) begin
            start_p <= 1'b1;
            if (store_en) begin
              state   <= ST_HDR;
              wr_pos  <= wcsr;
              units   <= '0;
              pay_cnt <= '0;
              hdr_idx <= '0;
            end else begin
              state <= ST_SKIP;
            end
          end
        end

        ST_HDR: begin
          if (space_ok) begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_pos;
            mem_wdata <= '0;
            if (hdr_idx == LEN_IDX) len_pos <= wr_pos;
            wr_pos  <= wr_nxt;
            units   <= units + 1'b1;
            hdr_idx <= hdr_idx + 1'b1;
            if (hdr_idx == HDR_LAST) state <= ST_PAY;
          end else begin
            state <= ST_SKIP;
            units <= '0;
            ovf   <= 1'b1;
          end
        end

        ST_PAY: begin
          if (in_end) begin
            state <= units[0] ? ST_PAD : ST_LEN;
          end else if (in_valid) begin
            if (space_ok) begin
              mem_we    <= 1'b1;
              mem_addr  <= wr_pos;
              mem_wdata <= in_data;
              wr_pos    <= wr_nxt;
              units     <= units + 1'b1;
              pay_cnt   <= pay_cnt + 1'b1;
            end else begin
              state <= ST_SKIP;
              units <= '0;
              ovf   <= 1'b1;
            end
          end
        end

        ST_PAD: begin
          if (space_ok) begin
            mem_we    <= 1'b1;
            mem_addr  <= wr_pos;
            mem_wdata <= '0;
            wr_pos    <= wr_nxt;
            units     <= units + 1'b1;
            state     <= ST_LEN;
          end else begin
            state   <= ST_IDLE;
            units   <= '0;
            ovf     <= 1'b1;
            count_p <= 1'b1;
          end
        end

        ST_LEN: begin
          mem_we    <= 1'b1;
          mem_addr  <= len_pos;
          mem_wdata <= DW'({pay_cnt, 1'b0});
          wcsr      <= wr_pos;
          units     <= '0;
          done_p    <= 1'b1;
          count_p   <= 1'b1;
          state     <= ST_IDLE;
        end

        ST_SKIP: begin
          if (in_end) begin
            count_p <= 1'b1;
            state   <= ST_IDLE;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_even_footprint_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEN) |-> !units[0]);

  assert_units_track_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAY) |-> (units == AW'(HDR_HALFWORDS) + pay_cnt));

  assert_drop_keeps_cursor_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $stable(wcsr) && (units == '0));

  assert_done_counts_R9: assert property (@(posedge clk) disable iff (rst)
    done_p |-> count_p);

  assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    in_start |-> (state == ST_IDLE));

  assert_payload_window_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((state == ST_PAY) || (state == ST_SKIP)) && !in_end);

  assert_skip_no_store_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |=> !mem_we);
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] RST_BEGIN = '0,
  parameter logic [AW-1:0] RST_END   = AW'(1024)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic          ctl_store_en,
  input  logic          ctl_latch,
  input  logic [AW-1:0] cfg_begin,
  input  logic [AW-1:0] cfg_end,
  input  logic [AW-1:0] cfg_wlatch,
  input  logic [AW-1:0] rd_csr,
  input  logic          in_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_end,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rx_start,
  output logic          rx_done,
  output logic          rx_count,
  output logic [AW-1:0] hw_wcsr,
  output logic [AW-1:0] rx_units,
  output logic          rx_ovf
);
  logic [AW-1:0] act_begin;
  logic [AW-1:0] act_end;
  logic          store_en;
  logic          latch_evt;

  rxring_cfg #(
    .AW(AW), .RST_BEGIN(RST_BEGIN), .RST_END(RST_END)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .ctl_wr      (ctl_wr),
    .ctl_store_en(ctl_store_en),
    .ctl_latch   (ctl_latch),
    .cfg_begin   (cfg_begin),
    .cfg_end     (cfg_end),
    .act_begin   (act_begin),
    .act_end     (act_end),
    .store_en    (store_en),
    .latch_evt   (latch_evt)
  );

  rxring_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .act_begin(act_begin),
    .act_end  (act_end),
    .store_en (store_en),
    .latch_evt(latch_evt),
    .wlatch   (cfg_wlatch),
    .rd_csr   (rd_csr),
    .in_start (in_start),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_end   (in_end),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .start_p  (rx_start),
    .done_p   (rx_done),
    .count_p  (rx_count),
    .wcsr     (hw_wcsr),
    .units    (rx_units),
    .ovf      (rx_ovf)
  );

  assert_write_in_ring_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (act_begin < act_end)) |-> (mem_addr >= act_begin) && (mem_addr < act_end));

  assert_pulse_once_R9: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
endmodule

// File: tb/rxring_ctrl_tb.sv
module rxring_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NV = 5;
  localparam int VLEN [NV]  = '{0, 1, 2, 3, 6};
  localparam int VSEED[NV]  = '{16'h1000, 16'h2200, 16'h3300, 16'h4400, 16'h5500};
  localparam int VFOOT[NV]  = '{6, 8, 8, 10, 12};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 0, ctl_store_en = 0, ctl_latch = 0;
  logic [AW-1:0] cfg_begin = '0, cfg_end = '0, cfg_wlatch = '0, rd_csr = '0;
  logic          in_start = 0, in_valid = 0, in_end = 0;
  logic [DW-1:0] in_data = '0;
  logic          mem_we, rx_start, rx_done, rx_count, rx_ovf;
  logic [AW-1:0] mem_addr, hw_wcsr, rx_units;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] mem [4096];
  int n_wr = 0, n_start = 0, n_done = 0, n_count = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rxring_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_store_en(ctl_store_en),
    .ctl_latch(ctl_latch), .cfg_begin(cfg_begin), .cfg_end(cfg_end),
    .cfg_wlatch(cfg_wlatch), .rd_csr(rd_csr), .in_start(in_start),
    .in_valid(in_valid), .in_data(in_data), .in_end(in_end),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_start(rx_start), .rx_done(rx_done), .rx_count(rx_count),
    .hw_wcsr(hw_wcsr), .rx_units(rx_units), .rx_ovf(rx_ovf)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        n_wr <= n_wr + 1;
      end
      if (rx_start) n_start <= n_start + 1;
      if (rx_done)  n_done  <= n_done + 1;
      if (rx_count) n_count <= n_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input bit en, input bit lat);
    @(negedge clk);
    ctl_wr = 1; ctl_store_en = en; ctl_latch = lat;
    @(negedge clk);
    ctl_wr = 0; ctl_store_en = 0; ctl_latch = 0;
  endtask

  task automatic send(input int n, input logic [15:0] seed, input bit chk_units);
    @(negedge clk);
    in_start = 1;
    @(negedge clk);
    in_start = 0;
    repeat (7) @(negedge clk);
    if (chk_units) check("R8 units after header", 32'(rx_units), 32'd6);
    for (int j = 0; j < n; j++) begin
      in_valid = 1; in_data = seed + 16'(j);
      @(negedge clk);
    end
    in_valid = 0;
    in_end = 1;
    @(negedge clk);
    in_end = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base, exp_w;
    int wr0, d0, c0, s0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 wcsr", 32'(hw_wcsr), 0);
    check("R1 units", 32'(rx_units), 0);
    check("R1 ovf", 32'(rx_ovf), 0);
    check("R1 outputs idle", {29'd0, mem_we, rx_done, rx_count}, 0);
    // R1: storing disabled after reset
    s0 = n_start; c0 = n_count;
    send(2, 16'hAAAA, 0);
    check("R1 no store after reset", 32'(n_wr), 0);
    check("R9 start pulse", 32'(n_start - s0), 1);
    check("R9 count pulse", 32'(n_count - c0), 1);

    // R2 latch ring 0x100..0x400, cursor 0x100
    cfg_begin = 12'h100; cfg_end = 12'h400; cfg_wlatch = 12'h100; rd_csr = 12'h100;
    ctl(1, 1);
    check("R2 latched cursor", 32'(hw_wcsr), 32'h100);

    // Vector table: main function R4 R5
    for (int i = 0; i < NV; i++) begin
      base = hw_wcsr; d0 = n_done;
      send(VLEN[i], 16'(VSEED[i]), 1);
      exp_w = base + AW'(VFOOT[i]);
      check("R5 cursor advance", 32'(hw_wcsr), 32'(exp_w));
      check("R4 length field", 32'(mem[base + 4]), 32'(2 * VLEN[i]));
      check("R4 header zero", 32'(mem[base]), 0);
      for (int j = 0; j < VLEN[i]; j++)
        check("R4 payload", 32'(mem[base + 6 + AW'(j)]), 32'(VSEED[i] + j));
      if ((6 + VLEN[i]) % 2 == 1)
        check("R5 pad zero", 32'(mem[base + 6 + AW'(VLEN[i])]), 0);
      check("R9 done pulse", 32'(n_done - d0), 1);
      check("R8 units cleared", 32'(rx_units), 0);
    end

    // R2: staged values without latch have no effect
    base = hw_wcsr;
    cfg_begin = 12'h010; cfg_end = 12'h030; cfg_wlatch = 12'h020;
    ctl(1, 0);
    send(1, 16'h6600, 1);
    check("R2 no effect without latch", 32'(hw_wcsr), 32'(base + 8));
    check("R2 data at old cursor", 32'(mem[base + 6]), 32'h6600);

    // R3 disabled
    base = hw_wcsr; wr0 = n_wr; d0 = n_done; c0 = n_count;
    ctl(0, 0);
    send(3, 16'h7700, 0);
    check("R3 no writes", 32'(n_wr - wr0), 0);
    check("R3 cursor kept", 32'(hw_wcsr), 32'(base));
    check("R3 no done", 32'(n_done - d0), 0);
    check("R9 count when disabled", 32'(n_count - c0), 1);

    // Small ring 0x10..0x30, R6 R7
    cfg_begin = 12'h010; cfg_end = 12'h030; cfg_wlatch = 12'h010; rd_csr = 12'h010;
    ctl(1, 1);
    check("R2 small ring cursor", 32'(hw_wcsr), 32'h010);
    send(20, 16'h8000, 1);
    check("R5 big frame commit", 32'(hw_wcsr), 32'h02A);
    // collision: header hits the read cursor
    wr0 = n_wr; d0 = n_done; c0 = n_count;
    send(4, 16'h9000, 0);
    check("R7 cursor unchanged", 32'(hw_wcsr), 32'h02A);
    check("R7 units cleared", 32'(rx_units), 0);
    check("R7 ovf set", 32'(rx_ovf), 1);
    check("R7 no done", 32'(n_done - d0), 0);
    check("R9 count on drop", 32'(n_count - c0), 1);
    check("R7 writes stop before reader", 32'(n_wr - wr0), 5);
    // wrap
    rd_csr = 12'h020;
    send(4, 16'hB000, 1);
    check("R6 wrapped cursor", 32'(hw_wcsr), 32'h014);
    check("R6 payload at ring start", 32'(mem[12'h010]), 32'hB000);
    check("R6 payload last", 32'(mem[12'h013]), 32'hB003);
    check("R6 length before wrap", 32'(mem[12'h02E]), 8);
    check("R7 ovf sticky", 32'(rx_ovf), 1);
    cfg_wlatch = 12'h014;
    ctl(1, 1);
    check("R7 ovf cleared by latch", 32'(rx_ovf), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule